// File: doc/BRIEF.md
# SHA-256 Compression Engine with In-RAM Operands

This block performs one SHA-256 compression on operands that already sit in a shared scratch RAM. Software places sixteen message words, the eight-word chaining state and the sixty-four round constants in RAM. It then points two coarse base registers at those regions and sets a start bit in a byte-wide register window. The engine takes the RAM port and reads every operand. It expands the message schedule in a 16-word sliding window and runs the 64 rounds. Finally it writes the updated chaining state back over the old one.

Padding, length appending, byte ordering of raw input and chaining across blocks are left to software. A multi-block hash is formed by rewriting the message words and starting again. The previous result is still in place in RAM and becomes the next chaining state.

Top module: `sha_mem_engine`

## Requirements
- R1: After reset, `busy` is 0, every register offset reads 0x00, and `ram_en` is 0.
- R2: A write to offset 0 with bit 1 set starts one compression while idle. While running, offset 0 reads 0x03 (bit 1 = start still set, bit 0 = busy). Both bits clear when the compression ends. A write to offset 0 with bit 1 clear starts nothing.
- R3: Offset 1 (message/state region) and offset 2 (constant region) keep write bits [7:2] as region bits and read bits [1:0] as 0. A region begins at RAM word address (register bits [7:2]) × 64, which is byte address bits [13:8].
- R4: Operands are read from fixed word offsets. The message word W[i] is at region word i (i = 0..15), read as a big-endian 32-bit word with bits [31:24] as the first byte. The state word H[i] is at region word 24+i (byte offset 0x60). The round constant K[t] is at constant-region word t.
- R5: At the end, each new H[i] (old H[i] plus working variable i) is written to state word 24+i, in order i = 0..7. These are the only RAM writes, and the reserved words 16..23 are untouched.
- R6: The RAM port is driven only while `busy` is 1. `busy` stays 1 for exactly 97 clock cycles after the edge that captures the start write (25 fetch, 64 round, 8 writeback).
- R7: The written state equals the SHA-256 compression of the stored W and H with the stored K. The schedule is extended as W[t] = σ1(W[t-2]) + W[t-7] + σ0(W[t-15]) + W[t-16].
- R8: While busy, writes to the base registers and further start requests have no effect.
- R9: A second start with new W words uses the state left in RAM by the first, and so gives the chained two-block result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register offset for write |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_sel | input | 2 | Register offset for read |
| reg_rd_data | output | 8 | Register read data (combinational) |
| busy | output | 1 | Compression in progress, RAM port owned |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid one cycle after a read |

## Verification
An error in the fetch index, the schedule window or a single round corrupts the chaining state. That corruption appears in all eight writeback words within the 97-cycle window, so one data compare per word catches it. A bad sequencing counter shows earlier and more directly. It moves `busy` off its fixed 97-cycle length, sends a write outside words 24..31, or puts the reserved gap at risk. Stale base or control state is visible at once on the register read port. A second chained block shows whether writeback really landed in place.

// File: rtl/sha_eng_pkg.sv
package sha_eng_pkg;
    localparam int WORD_W     = 32;
    localparam int N_HWORDS   = 8;
    localparam int N_WWORDS   = 16;
    localparam int N_ROUNDS   = 64;
    localparam int H_WORD_OFS = 24;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [N_HWORDS-1:0] hvec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ROUND, ST_WBACK} eng_state_e;

    typedef struct packed {
        logic       valid;
        logic [4:0] idx;
    } rd_tag_t;

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_s0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_s1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(word_t e, word_t f, word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t majority(word_t a, word_t b, word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction
endpackage

// File: rtl/sha_eng_regs.sv
module sha_eng_regs #(
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8,
    parameter int BASE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    output logic              start_req,
    output logic [BASE_W-1:0] base_w,
    output logic [BASE_W-1:0] base_k
);
    localparam int LOW_W     = DATA_W - BASE_W;
    localparam int START_BIT = 1;
    localparam int BUSY_BIT  = 0;
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_WH   = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_K    = SEL_W'(2);

    logic unused_low;
    assign unused_low = wr_data[BUSY_BIT];

    // R2/R8: start only from idle
    assign start_req = wr_en && !busy && (wr_sel == SEL_CTRL) && wr_data[START_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_w <= '0;
            base_k <= '0;
        end else if (wr_en && !busy) begin
            if (wr_sel == SEL_WH) base_w <= wr_data[DATA_W-1:LOW_W];
            if (wr_sel == SEL_K)  base_k <= wr_data[DATA_W-1:LOW_W];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL: begin
                rd_data[START_BIT] = busy;
                rd_data[BUSY_BIT]  = busy;
            end
            SEL_WH:  rd_data = {base_w, {LOW_W{1'b0}}};
            SEL_K:   rd_data = {base_k, {LOW_W{1'b0}}};
            default: rd_data = '0;
        endcase
    end

    // R8: base registers frozen while the engine runs
    p_base_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> ($stable(base_w) && $stable(base_k)));
endmodule

// File: rtl/sha_eng_sched.sv
module sha_eng_sched
    import sha_eng_pkg::*;
(
    input  logic  clk,
    input  logic  push,
    input  logic  shift,
    input  word_t din,
    output word_t w_cur
);
    word_t win [N_WWORDS];
    word_t w_next;
    word_t tail;

    // W[t+16] from W[t+14], W[t+9], W[t+1], W[t]
    assign w_next = small_s1(win[N_WWORDS-2]) + win[N_WWORDS-7]
                  + small_s0(win[1]) + win[0];
    assign tail   = push ? din : w_next;
    assign w_cur  = win[0];

    always_ff @(posedge clk) begin
        if (push || shift) begin
            for (int i = 0; i < N_WWORDS - 1; i++) win[i] <= win[i+1];
            win[N_WWORDS-1] <= tail;
        end
    end
endmodule

// File: rtl/sha_eng_round.sv
module sha_eng_round
    import sha_eng_pkg::*;
(
    input  hvec_t cur,
    input  word_t k,
    input  word_t w,
    output hvec_t nxt
);
    word_t t1, t2;

    always_comb begin
        t1 = cur[7] + big_s1(cur[4]) + choose(cur[4], cur[5], cur[6]) + k + w;
        t2 = big_s0(cur[0]) + majority(cur[0], cur[1], cur[2]);
        nxt[0] = t1 + t2;
        nxt[1] = cur[0];
        nxt[2] = cur[1];
        nxt[3] = cur[2];
        nxt[4] = cur[3] + t1;
        nxt[5] = cur[4];
        nxt[6] = cur[5];
        nxt[7] = cur[6];
    end
endmodule

// File: rtl/sha_mem_engine.sv
module sha_mem_engine
    import sha_eng_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE_W = 6,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [SEL_W-1:0]  reg_rd_sel,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              busy,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata
);
    localparam int OFS_W = ADDR_W - BASE_W;
    localparam int CNT_W = 7;
    localparam int IDX_W = 5;
    localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(N_WWORDS + N_HWORDS);
    localparam logic [CNT_W-1:0] W_END      = CNT_W'(N_WWORDS);
    localparam logic [CNT_W-1:0] ROUND_LAST = CNT_W'(N_ROUNDS - 1);
    localparam logic [CNT_W-1:0] WB_LAST    = CNT_W'(N_HWORDS - 1);
    localparam logic [IDX_W-1:0] IDX_W_END  = IDX_W'(N_WWORDS);
    localparam logic [ADDR_W-1:0] H_OFS     = ADDR_W'(H_WORD_OFS);

    eng_state_e        st;
    logic [CNT_W-1:0]  cnt;
    rd_tag_t           tag;
    hvec_t             hst, work, nxt;
    word_t             w_cur;
    logic              start_req;
    logic [BASE_W-1:0] base_w, base_k;
    logic [ADDR_W-1:0] w_area, k_area;

    assign busy   = (st != ST_IDLE);
    assign w_area = {base_w, {OFS_W{1'b0}}};
    assign k_area = {base_k, {OFS_W{1'b0}}};

    sha_eng_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
        .wr_data(reg_wr_data), .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
        .busy(busy), .start_req(start_req), .base_w(base_w), .base_k(base_k)
    );

    sha_eng_sched u_sched (
        .clk(clk),
        .push(tag.valid && (tag.idx < IDX_W_END)),
        .shift(st == ST_ROUND),
        .din(ram_rdata),
        .w_cur(w_cur)
    );

    sha_eng_round u_round (.cur(work), .k(ram_rdata), .w(w_cur), .nxt(nxt));

    // RAM port sequencing: reads are one cycle ahead of their use
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = w_area;
        ram_wdata = hst[cnt[2:0]];
        case (st)
            ST_FETCH: begin
                ram_en = 1'b1;
                if (cnt < W_END)
                    ram_addr = w_area + ADDR_W'(cnt);
                else if (cnt < FETCH_LAST)
                    ram_addr = w_area + H_OFS + ADDR_W'(cnt - W_END);
                else
                    ram_addr = k_area;
            end
            ST_ROUND: begin
                ram_en   = (cnt != ROUND_LAST);
                ram_addr = k_area + ADDR_W'(cnt) + ADDR_W'(1);
            end
            ST_WBACK: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = w_area + H_OFS + ADDR_W'(cnt);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            tag <= '0;
        end else begin
            tag <= '{valid: (st == ST_FETCH) && (cnt < FETCH_LAST), idx: cnt[IDX_W-1:0]};
            case (st)
                ST_IDLE: if (start_req) begin
                    st  <= ST_FETCH;
                    cnt <= '0;
                end
                ST_FETCH: if (cnt == FETCH_LAST) begin
                    st  <= ST_ROUND;
                    cnt <= '0;
                end else cnt <= cnt + CNT_W'(1);
                ST_ROUND: if (cnt == ROUND_LAST) begin
                    st  <= ST_WBACK;
                    cnt <= '0;
                end else cnt <= cnt + CNT_W'(1);
                ST_WBACK: if (cnt == WB_LAST) begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + CNT_W'(1);
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (tag.valid && (tag.idx >= IDX_W_END)) begin
            hst[tag.idx[2:0]]  <= ram_rdata;
            work[tag.idx[2:0]] <= ram_rdata;
        end
        if (st == ST_ROUND) begin
            work <= nxt;
            if (cnt == ROUND_LAST)
                for (int i = 0; i < N_HWORDS; i++) hst[i] <= hst[i] + nxt[i];
        end
    end

    // R6: no RAM traffic outside a compression
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ram_en);

    // R5: writes land only on the state words of the active region
    p_wb_target_r5: assert property (@(posedge clk) disable iff (rst)
        (ram_en && ram_we) |-> ((ram_addr - w_area) >= H_OFS &&
                                (ram_addr - w_area) < H_OFS + ADDR_W'(N_HWORDS)));

    // R2: a compression begins only on a start request
    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_req));

    // R4: the cycle after the last fetch read, the port reads constants
    p_kfetch_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_FETCH && st == ST_ROUND) |-> (ram_en && !ram_we));
endmodule

// File: tb/sha_mem_engine_bench.sv
module sha_mem_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int WORDS      = 1 << ADDR_W;
    localparam int RUN_CYCLES = 97;

    localparam logic [31:0] KTAB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };
    localparam logic [31:0] IV [8] = '{
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic [1:0]        reg_wr_sel = '0;
    logic [7:0]        reg_wr_data = '0;
    logic [1:0]        reg_rd_sel = '0;
    logic [7:0]        reg_rd_data;
    logic              busy, ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [31:0]       ram_wdata;
    logic [31:0]       ram_rdata = '0;

    logic [31:0] mem [WORDS];

    typedef struct { logic [ADDR_W-1:0] addr; logic [31:0] data; } exp_t;
    exp_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha_mem_engine u_sha_mem_engine (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .busy(busy), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected writeback items as the design writes
    always @(negedge clk) begin
        if (!rst && ram_en && ram_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected write", {20'b0, ram_addr}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(ram_addr == e.addr, "R5", "writeback address", {20'b0, ram_addr}, {20'b0, e.addr});
                chk(ram_wdata == e.data, "R7", "writeback data", ram_wdata, e.data);
            end
        end
    end

    function automatic logic [31:0] rr(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic ref_compress(input logic [31:0] hin [8], input logic [31:0] m [16],
                                output logic [31:0] hout [8]);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        for (int t = 0; t < 16; t++) w[t] = m[t];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        for (int i = 0; i < 8; i++) v[i] = hin[i];
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KTAB[t] + w[t];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) hout[i] = hin[i] + v[i];
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] data);
        @(negedge clk);
        reg_rd_sel = sel;
        #1 data = reg_rd_data;
    endtask

    // Driver: places operands, pushes expected writes, starts and times a run
    task automatic run_block(input logic [5:0] wb, input logic [5:0] kb,
                             input logic [31:0] m [16], input bit load_iv,
                             input bit inject, input string req,
                             output logic [31:0] hout [8]);
        int wbase, kbase, n;
        logic [31:0] hin [8];
        logic [31:0] gap [8];
        logic [7:0]  rd;
        wbase = int'(wb) * 64;
        kbase = int'(kb) * 64;
        reg_write(2'd1, {wb, 2'b01});
        reg_write(2'd2, {kb, 2'b10});
        for (int t = 0; t < 64; t++) mem[kbase + t] = KTAB[t];
        for (int i = 0; i < 16; i++) mem[wbase + i] = m[i];
        for (int i = 0; i < 8; i++) begin
            if (load_iv) mem[wbase + 24 + i] = IV[i];
            hin[i] = mem[wbase + 24 + i];
            gap[i] = mem[wbase + 16 + i];
        end
        ref_compress(hin, m, hout);
        for (int i = 0; i < 8; i++) exp_q.push_back('{ADDR_W'(wbase + 24 + i), hout[i]});
        @(negedge clk);
        reg_rd_sel = 2'd0;
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 8'h02;
        n = 0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
            if (n == 5) chk(reg_rd_data == 8'h03, "R2", "ctrl while running", {24'b0, reg_rd_data}, 32'h3);
            if (inject && n == 10) begin
                reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = 8'hFC;
            end else if (inject && n == 11) begin
                reg_wr_sel = 2'd0; reg_wr_data = 8'h02;
            end else if (inject && n == 12) begin
                reg_wr_sel = 2'd2; reg_wr_data = 8'hFC;
            end else begin
                reg_wr_en = 1'b0;
            end
            if (n > 400) break;
        end
        reg_wr_en = 1'b0;
        chk(n == RUN_CYCLES, req, "busy length", n, RUN_CYCLES);
        #1 chk(reg_rd_data == 8'h00, "R2", "ctrl after finish", {24'b0, reg_rd_data}, 32'h0);
        chk(exp_q.size() == 0, "R5", "writes outstanding", exp_q.size(), 0);
        for (int i = 0; i < 8; i++)
            chk(mem[wbase + 16 + i] == gap[i], "R5", "reserved gap kept", mem[wbase + 16 + i], gap[i]);
        reg_read(2'd1, rd);
        chk(rd == {wb, 2'b00}, "R8", "state base kept", {24'b0, rd}, {24'b0, wb, 2'b00});
        reg_read(2'd2, rd);
        chk(rd == {kb, 2'b00}, "R8", "constant base kept", {24'b0, rd}, {24'b0, kb, 2'b00});
        // second start inside the run was ignored: no further run begins
        @(negedge clk);
        chk(busy == 1'b0, "R8", "no restart", {31'b0, busy}, 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  rd;
        logic [31:0] m [16];
        logic [31:0] hres [8];
        logic [31:0] sha_abc [8];
        sha_abc = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                    32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
        for (int i = 0; i < WORDS; i++) mem[i] = 32'(i) * 32'h9e3779b9;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", {31'b0, busy}, 32'h0);
        chk(ram_en == 1'b0, "R1", "ram idle after reset", {31'b0, ram_en}, 32'h0);
        for (int s = 0; s < 4; s++) begin
            reg_read(2'(s), rd);
            chk(rd == 8'h00, "R1", "register after reset", {24'b0, rd}, 32'h0);
        end

        // R3: base register field placement
        reg_write(2'd1, 8'h17);
        reg_read(2'd1, rd);
        chk(rd == 8'h14, "R3", "state base readback", {24'b0, rd}, 32'h14);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, rd);
        chk(rd == 8'hFC, "R3", "constant base readback", {24'b0, rd}, 32'hFC);

        // R2: a control write without bit 1 starts nothing
        reg_write(2'd0, 8'h01);
        chk(busy == 1'b0, "R2", "no start without bit1", {31'b0, busy}, 32'h0);
        chk(ram_en == 1'b0, "R6", "no ram traffic", {31'b0, ram_en}, 32'h0);

        // R4/R7/R8: single padded "abc" block, nonzero bases, late writes during run
        for (int i = 0; i < 16; i++) m[i] = 32'h0;
        m[0]  = 32'h61626380;
        m[15] = 32'h00000018;
        run_block(6'd3, 6'd9, m, 1'b1, 1'b1, "R6", hres);
        for (int i = 0; i < 8; i++)
            chk(hres[i] == sha_abc[i], "R7", "reference digest", hres[i], sha_abc[i]);
        for (int i = 0; i < 8; i++)
            chk(mem[3*64 + 24 + i] == sha_abc[i], "R4", "digest in ram", mem[3*64 + 24 + i], sha_abc[i]);

        // R9: chained block, state taken from what the engine left in RAM
        for (int i = 0; i < 16; i++) m[i] = 32'h01234567 ^ (32'(i) * 32'h11111111);
        run_block(6'd3, 6'd9, m, 1'b0, 1'b0, "R9", hres);

        // R3/R4: extreme bases, message all ones
        for (int i = 0; i < 16; i++) m[i] = 32'hFFFFFFFF;
        run_block(6'd63, 6'd0, m, 1'b1, 1'b0, "R6", hres);

        summary();
        $finish;
    end
endmodule